// File: doc/BRIEF.md
# Serial Audio Frame Deserializer

This block is the receiving end of a time-slotted serial audio link. It runs on the falling edge of the link's bit clock and watches a frame marker line and a serial data line. When it sees the frame marker go from low to high, it treats that edge as the start of a frame. It then shifts in a 256-bit frame, most significant bit first. The frame holds a 16-bit tag word followed by twelve 20-bit slot words.

When the last bit has arrived, the block publishes the whole frame at once. This covers the frame-valid flag, one valid flag per slot, the 2-bit codec identifier and the twelve slot words. A one-cycle ready strobe marks the update. Slots whose tag flag is clear are reported as zero. The block also checks the frame marker for framing faults: a marker that drops too early, or one that rises again before the frame is finished. Such a frame is dropped and a one-cycle error pulse is raised.

Top module: `sfrm_rx`

## Requirements
- R1: While reset is asserted, and after its release until the first frame completes, frameReady, framingErr, frameValid, slotValid, codecId and slotData are all zero. Activity on sdoIn with syncIn held low never produces a frame.
- R2: A frame starts at the falling bitClk edge where syncIn is sampled high after being sampled low at the previous falling edge. The next 256 falling edges carry frame bits 0 to 255 on sdoIn.
- R3: Tag decoding uses bits 0 to 15. Bit 0 drives frameValid. Bits 1 to 12 drive slotValid[0] to slotValid[11] (slot 1 to slot 12). Bit 13 is ignored. Bit 14 drives codecId[1] and bit 15 drives codecId[0].
- R4: Slot k (k = 1..12) occupies frame bits 16+20(k-1) to 35+20(k-1), MSB first, and is reported on slotData[20(k-1)+19 : 20(k-1)].
- R5: A slot whose valid flag in the tag is 0 is reported as all zeros, whatever was received in its bit positions.
- R6: All decoded outputs update together at the falling edge that samples bit 255. frameReady is high for exactly the bit-clock cycle that follows that edge. Otherwise the outputs hold their values.
- R7: A syncIn rise sampled at the same edge as bit 255 completes the current frame and starts the next one without a framing error, so frames can follow back to back.
- R8: If syncIn is sampled low together with any of frame bits 0 to 14, framingErr pulses for one cycle. The frame is dropped (no frameReady, outputs hold) and the receiver waits for the next rise.
- R9: If syncIn rises with any of frame bits 0 to 254, framingErr pulses for one cycle and the partial frame is dropped. That edge starts a new frame.
- R10: When no frame is in progress and syncIn stays low, sdoIn is ignored and neither frameReady nor framingErr is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bitClk | input | 1 | Link bit clock; all sampling happens on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Frame marker line |
| sdoIn | input | 1 | Serial frame data, MSB first |
| frameReady | output | 1 | One-cycle strobe: a complete frame has been published |
| framingErr | output | 1 | One-cycle strobe: a frame was dropped for a marker fault |
| frameValid | output | 1 | Frame-valid flag of the last completed frame |
| slotValid | output | 12 | Per-slot valid flags, bit 0 = slot 1 |
| codecId | output | 2 | Codec identifier field of the last completed frame |
| slotData | output | 240 | Twelve 20-bit slot words, slot 1 in the low 20 bits |

## Verification
Back-to-back frames are streamed with tags that set all flags, none, alternating flags, and the ignored reserved bit. These tell a correct flag-to-slot mapping apart from a shifted or reversed one, and show whether the codec identifier bits are swapped. Invalid slots carry nonzero bit patterns, so a receiver that skips zero-forcing is exposed. Marker faults are applied at the edges of the allowed windows: a drop with bit 14 versus bit 3, and an early rise with bit 254 versus bit 100. These separate off-by-one window limits from correct ones. A marker held low around idle noise shows whether the receiver ever starts without a rising edge.

// File: rtl/sfrm_pkg.sv
package sfrm_pkg;

  // Strobes issued by the frame controller to the datapath each bit edge.
  typedef struct packed {
    logic shiftEn;  // a frame bit is being sampled at this edge
    logic commit;   // this edge samples the last bit: publish the frame
  } dpStrobe_t;

endpackage

// File: rtl/sfrm_ctrl.sv
module sfrm_ctrl
  import sfrm_pkg::*;
#(
  parameter int TAG_W      = 16,
  parameter int FRAME_BITS = 256
) (
  input  logic      bitClk,
  input  logic      rstN,
  input  logic      syncIn,
  output dpStrobe_t strobe,
  output logic      frameReady,
  output logic      framingErr
);

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);
  // Marker must stay high alongside bits 0 .. TAG_W-2.
  localparam logic [CNT_W-1:0] SYNC_HOLD = CNT_W'(TAG_W - 1);

  logic             syncPrev;
  logic             active;
  logic [CNT_W-1:0] cntReg;

  logic syncRise;
  logic lastBit;
  logic shortSync;
  logic earlyRise;

  always_comb begin
    syncRise  = syncIn && !syncPrev;
    lastBit   = active && (cntReg == LAST_CNT);
    shortSync = active && (cntReg < SYNC_HOLD) && !syncIn;
    earlyRise = active && !lastBit && syncRise;
    strobe.shiftEn = active;
    strobe.commit  = lastBit;
  end

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      syncPrev   <= 1'b1;
      active     <= 1'b0;
      cntReg     <= '0;
      frameReady <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      syncPrev   <= syncIn;
      frameReady <= lastBit;
      framingErr <= shortSync || earlyRise;
      if (syncRise) begin
        active <= 1'b1;
        cntReg <= '0;
      end else if (shortSync || lastBit) begin
        active <= 1'b0;
        cntReg <= '0;
      end else if (active) begin
        cntReg <= cntReg + 1'b1;
      end
    end
  end

  // R2: a sampled rise always aligns the bit counter to bit 0.
  p_start_align_r2 : assert property (@(negedge bitClk) disable iff (!rstN)
    (syncIn && !syncPrev) |=> (active && cntReg == '0));

  // R6: the publish strobe never lasts two cycles.
  p_ready_single_r6 : assert property (@(negedge bitClk) disable iff (!rstN)
    frameReady |=> !frameReady);

  // R8: a dropped frame is never also reported as complete.
  p_err_excl_r8 : assert property (@(negedge bitClk) disable iff (!rstN)
    frameReady |-> !framingErr);

  // R10: idle with the marker low stays silent.
  p_idle_quiet_r10 : assert property (@(negedge bitClk) disable iff (!rstN)
    (!active && !syncIn) |=> (!frameReady && !framingErr));

endmodule

// File: rtl/sfrm_dpath.sv
module sfrm_dpath
  import sfrm_pkg::*;
#(
  parameter int SLOTS      = 12,
  parameter int SLOT_W     = 20,
  parameter int ID_W       = 2,
  parameter int TAG_W      = 16,
  parameter int FRAME_BITS = 256
) (
  input  logic                    bitClk,
  input  logic                    rstN,
  input  logic                    sdoIn,
  input  dpStrobe_t               strobe,
  output logic                    frameValid,
  output logic [SLOTS-1:0]        slotValid,
  output logic [ID_W-1:0]         codecId,
  output logic [SLOTS*SLOT_W-1:0] slotData
);

  // Frame bit i sits at shiftNext[FRAME_BITS-1-i] on the commit edge.
  localparam int TOP     = FRAME_BITS - 1;
  localparam int ID_LSB  = FRAME_BITS - TAG_W;
  localparam int RSV_POS = FRAME_BITS - TAG_W + ID_W;
  localparam int DATA_HI = FRAME_BITS - 1 - TAG_W;

  logic [FRAME_BITS-2:0] shiftReg;
  logic [FRAME_BITS-1:0] shiftNext;
  logic                  unusedRsvd;

  assign shiftNext  = {shiftReg, sdoIn};
  assign unusedRsvd = shiftNext[RSV_POS];

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= shiftNext[FRAME_BITS-2:0];
    end
  end

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      frameValid <= 1'b0;
      codecId    <= '0;
    end else if (strobe.commit) begin
      frameValid <= shiftNext[TOP];
      codecId    <= shiftNext[ID_LSB +: ID_W];
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [SLOT_W-1:0] rawWord;
    logic              flag;

    assign rawWord = shiftNext[DATA_HI - k*SLOT_W -: SLOT_W];
    assign flag    = shiftNext[TOP - 1 - k];

    always_ff @(negedge bitClk or negedge rstN) begin
      if (!rstN) begin
        slotValid[k]                  <= 1'b0;
        slotData[k*SLOT_W +: SLOT_W]  <= '0;
      end else if (strobe.commit) begin
        slotValid[k]                  <= flag;
        slotData[k*SLOT_W +: SLOT_W]  <= flag ? rawWord : '0;
      end
    end

    // R5: an invalid slot never reports nonzero data.
    p_zero_invalid_r5 : assert property (@(negedge bitClk) disable iff (!rstN)
      !slotValid[k] |-> (slotData[k*SLOT_W +: SLOT_W] == '0));
  end

  // R6: published values move only on the commit strobe.
  p_hold_r6 : assert property (@(negedge bitClk) disable iff (!rstN)
    !strobe.commit |=> ($stable(slotData) && $stable(slotValid)
                        && $stable(frameValid) && $stable(codecId)));

endmodule

// File: rtl/sfrm_rx.sv
module sfrm_rx
  import sfrm_pkg::*;
#(
  parameter int SLOTS  = 12,
  parameter int SLOT_W = 20,
  parameter int ID_W   = 2
) (
  input  logic                    bitClk,
  input  logic                    rstN,
  input  logic                    syncIn,
  input  logic                    sdoIn,
  output logic                    frameReady,
  output logic                    framingErr,
  output logic                    frameValid,
  output logic [SLOTS-1:0]        slotValid,
  output logic [ID_W-1:0]         codecId,
  output logic [SLOTS*SLOT_W-1:0] slotData
);

  // Tag: frame flag, one flag per slot, a reserved bit, then the ID field.
  localparam int TAG_W      = 1 + SLOTS + 1 + ID_W;
  localparam int FRAME_BITS = TAG_W + SLOTS * SLOT_W;

  dpStrobe_t strobe;

  sfrm_ctrl #(
    .TAG_W      (TAG_W),
    .FRAME_BITS (FRAME_BITS)
  ) u_ctrl (
    .bitClk     (bitClk),
    .rstN       (rstN),
    .syncIn     (syncIn),
    .strobe     (strobe),
    .frameReady (frameReady),
    .framingErr (framingErr)
  );

  sfrm_dpath #(
    .SLOTS      (SLOTS),
    .SLOT_W     (SLOT_W),
    .ID_W       (ID_W),
    .TAG_W      (TAG_W),
    .FRAME_BITS (FRAME_BITS)
  ) u_dpath (
    .bitClk     (bitClk),
    .rstN       (rstN),
    .sdoIn      (sdoIn),
    .strobe     (strobe),
    .frameValid (frameValid),
    .slotValid  (slotValid),
    .codecId    (codecId),
    .slotData   (slotData)
  );

endmodule

// File: tb/sim_sfrm_rx.sv
module sim_sfrm_rx;

  localparam int CLK_PERIOD = 10;
  localparam int NSLOT  = 12;
  localparam int SW     = 20;
  localparam int NVEC   = 6;
  localparam int NO_RISE = -1;

  // {tag, seed}
  localparam logic [47:0] VECS [NVEC] = '{
    {16'hFFF8, 32'h0000_0011},
    {16'h8001, 32'h0000_0022},
    {16'hD556, 32'h0000_0033},
    {16'h2AAB, 32'h0000_0044},
    {16'hFFFF, 32'h0000_0055},
    {16'h0000, 32'h0000_0066}
  };

  logic              bitClk;
  logic              rstN;
  logic              syncIn;
  logic              sdoIn;
  logic              frameReady;
  logic              framingErr;
  logic              frameValid;
  logic [NSLOT-1:0]  slotValid;
  logic [1:0]        codecId;
  logic [NSLOT*SW-1:0] slotData;

  int checks   = 0;
  int failures = 0;
  int readyCnt = 0;
  int errCnt   = 0;
  bit done     = 0;

  sfrm_rx u0 (
    .bitClk     (bitClk),
    .rstN       (rstN),
    .syncIn     (syncIn),
    .sdoIn      (sdoIn),
    .frameReady (frameReady),
    .framingErr (framingErr),
    .frameValid (frameValid),
    .slotValid  (slotValid),
    .codecId    (codecId),
    .slotData   (slotData)
  );

  initial bitClk = 1'b0;
  always #(CLK_PERIOD/2) bitClk = ~bitClk;

  // Outputs change on falling edges; count strobes at rising edges.
  always @(posedge bitClk) begin
    if (frameReady) readyCnt <= readyCnt + 1;
    if (framingErr) errCnt   <= errCnt + 1;
  end

  function automatic logic [SW-1:0] slotVal(input logic [31:0] seed, input int k);
    logic [31:0] t;
    t = seed * 32'h0001_3579 + (k + 1) * 32'h0009_E3B1;
    return t[SW-1:0] ^ 20'h5A5A5;
  endfunction

  function automatic logic frameBit(input logic [15:0] tag, input logic [31:0] seed, input int i);
    logic [SW-1:0] v;
    if (i < 16) return tag[15 - i];
    v = slotVal(seed, (i - 16) / SW);
    return v[SW - 1 - ((i - 16) % SW)];
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkFrame(input logic [15:0] tag, input logic [31:0] seed, input bit zeroAll);
    logic [NSLOT*SW-1:0] expData;
    logic [NSLOT-1:0]    expValid;
    logic                expFv;
    logic [1:0]          expId;
    expData = '0;
    for (int k = 0; k < NSLOT; k++) begin
      expValid[k] = zeroAll ? 1'b0 : tag[14 - k];
      if (expValid[k]) expData[k*SW +: SW] = slotVal(seed, k);
    end
    expFv = zeroAll ? 1'b0 : tag[15];
    expId = zeroAll ? 2'b00 : tag[1:0];
    check(frameValid == expFv, "R3 frameValid", 256'(frameValid), 256'(expFv));
    check(slotValid == expValid, "R3 slotValid", 256'(slotValid), 256'(expValid));
    check(codecId == expId, "R3 codecId", 256'(codecId), 256'(expId));
    check(slotData == expData, "R4/R5 slotData", 256'(slotData), 256'(expData));
  endtask

  task automatic idleBits(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge bitClk);
      syncIn <= 1'b0;
      sdoIn  <= 1'($urandom);
    end
  endtask

  task automatic startEdge();
    @(posedge bitClk);
    syncIn <= 1'b1;
    sdoIn  <= 1'b0;
  endtask

  task automatic sendBits(input logic [15:0] tag, input logic [31:0] seed,
                          input int lowAt, input int riseAt, input int nBits);
    for (int i = 0; i < nBits; i++) begin
      @(posedge bitClk);
      syncIn <= (i < lowAt) || (i == riseAt);
      sdoIn  <= frameBit(tag, seed, i);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [15:0] lastTag;
    logic [31:0] lastSeed;
    rstN   = 1'b0;
    syncIn = 1'b0;
    sdoIn  = 1'b0;
    repeat (3) @(posedge bitClk);
    #1;
    // R1: reset state
    check(frameReady == 1'b0 && framingErr == 1'b0, "R1 strobes in reset",
          256'({frameReady, framingErr}), 256'(0));
    chkFrame(16'h0, 32'h0, 1'b1);
    @(posedge bitClk);
    rstN <= 1'b1;

    // R1/R10: noise with marker low never yields a frame
    idleBits(300);
    @(negedge bitClk); #1;
    check(readyCnt == 0, "R1 no frame before rise", 256'(readyCnt), 256'(0));
    check(errCnt == 0, "R10 no error when idle", 256'(errCnt), 256'(0));
    chkFrame(16'h0, 32'h0, 1'b1);

    // R2..R7: back-to-back frames from the vector table
    startEdge();
    for (int v = 0; v < NVEC; v++) begin
      sendBits(VECS[v][47:32], VECS[v][31:0], 15, (v < NVEC - 1) ? 255 : NO_RISE, 256);
      @(negedge bitClk); #1;
      check(frameReady == 1'b1, "R6 ready after bit 255", 256'(frameReady), 256'(1));
      chkFrame(VECS[v][47:32], VECS[v][31:0], 1'b0);
    end
    lastTag  = VECS[NVEC-1][47:32];
    lastSeed = VECS[NVEC-1][31:0];
    idleBits(40);
    check(readyCnt == NVEC, "R7 one ready per frame", 256'(readyCnt), 256'(NVEC));
    check(errCnt == 0, "R7 back-to-back no error", 256'(errCnt), 256'(0));

    // R6/R10: outputs hold through idle noise
    lastTag  = VECS[2][47:32];
    lastSeed = VECS[2][31:0];
    startEdge();
    sendBits(lastTag, lastSeed, 15, NO_RISE, 256);
    idleBits(300);
    #1;
    check(readyCnt == NVEC + 1, "R10 idle noise ignored", 256'(readyCnt), 256'(NVEC + 1));
    chkFrame(lastTag, lastSeed, 1'b0);

    // R8: marker drops with bit 14 (boundary)
    startEdge();
    sendBits(16'hFFF8, 32'h77, 14, NO_RISE, 256);
    idleBits(5);
    check(errCnt == 1, "R8 drop at bit 14", 256'(errCnt), 256'(1));
    check(readyCnt == NVEC + 1, "R8 dropped frame not ready", 256'(readyCnt), 256'(NVEC + 1));
    chkFrame(lastTag, lastSeed, 1'b0);

    // R8: marker drops with bit 3
    startEdge();
    sendBits(16'h8001, 32'h88, 3, NO_RISE, 256);
    idleBits(5);
    check(errCnt == 2, "R8 drop at bit 3", 256'(errCnt), 256'(2));
    chkFrame(lastTag, lastSeed, 1'b0);

    // Recovery frame after faults
    startEdge();
    sendBits(16'h2AAB, 32'h99, 15, NO_RISE, 256);
    @(negedge bitClk); #1;
    chkFrame(16'h2AAB, 32'h99, 1'b0);

    // R9: early rise with bit 100 restarts the frame
    startEdge();
    sendBits(16'hFFF8, 32'hAA, 15, 100, 101);
    sendBits(16'hD556, 32'hBB, 15, NO_RISE, 256);
    @(negedge bitClk); #1;
    check(frameReady == 1'b1, "R9 restarted frame ready", 256'(frameReady), 256'(1));
    chkFrame(16'hD556, 32'hBB, 1'b0);
    idleBits(5);
    check(errCnt == 3, "R9 early rise bit 100", 256'(errCnt), 256'(3));
    check(readyCnt == NVEC + 3, "R9 partial frame dropped", 256'(readyCnt), 256'(NVEC + 3));

    // R9: early rise with bit 254 (boundary)
    startEdge();
    sendBits(16'hFFFF, 32'hCC, 15, 254, 255);
    sendBits(16'h8001, 32'hDD, 15, NO_RISE, 256);
    @(negedge bitClk); #1;
    chkFrame(16'h8001, 32'hDD, 1'b0);
    idleBits(5);
    check(errCnt == 4, "R9 early rise bit 254", 256'(errCnt), 256'(4));
    check(readyCnt == NVEC + 4, "R9 bit 254 frame dropped", 256'(readyCnt), 256'(NVEC + 4));

    done = 1;
    finishRun();
  end

endmodule